// File: doc/BRIEF.md
# FRAM Identification Probe Sequencer

After reset, this block interrogates a ferroelectric RAM on an SPI bus and turns what it learns into a fixed configuration for the rest of the chip. It runs three short SPI transactions in SPI mode 0, using its own byte shifter. The first reads the status register. The second reads the 9-byte identification string. The third, which is optional, reads the 8-byte serial number. Each transaction is framed by its own chip-select pulse.

From the identification string the block takes the manufacturer byte, the density code and the serial-number flag. The density code gives the device size in bytes, and the size gives the number of address bytes that later accesses must send. When the device reports a serial number, the bytes are stored in the reverse of their arrival order.

When the sequence ends, the block raises a done flag. Its results then stay constant until the next reset. If the device is rejected, an error code gives the reason.

Top module: `fram_probe_seq`

## Requirements
- R1: While `rst_n` is low and at the first cycle after it: `spi_cs_n` is 1, `spi_sclk` is 0, and `probe_done`, `dev_present`, `err_code`, `byte_size`, `addr_bytes`, `sn_valid` and `serial_num` are all zero.
- R2: Each probe step is one chip-select frame in SPI mode 0: `spi_sclk` idles low, MOSI is sent MSB first and MISO is sampled on the rising edge. A frame carries one opcode byte followed by N received bytes. The steps are: status with opcode 0x05 and N=1, identification with opcode 0x9F and N=9, serial number with opcode 0xC3 and N=8. They are issued in that order. `spi_sclk` is low whenever `spi_cs_n` is high.
- R3: If bit 0 of the status byte is 1, the device is busy. The probe then ends after the status frame, with `dev_present`=0 and `err_code`=1.
- R4: Identification bytes are numbered from 0 in arrival order. If byte 6 is not 0xC2, the probe ends with `dev_present`=0 and `err_code`=2, and no serial frame is issued.
- R5: If byte 6 is correct but byte 7 is outside 0x21..0x26, the probe ends with `dev_present`=0 and `err_code`=3. A wrong byte 6 takes priority over a wrong byte 7.
- R6: For an accepted device, `byte_size` = 2^(byte7 − 0x21 + 14). This runs from 16384 bytes for code 0x21 to 524288 bytes for code 0x26.
- R7: For an accepted device, `addr_bytes` is 3 when `byte_size` exceeds 65536, and 2 otherwise.
- R8: For an accepted device, a serial frame is issued only when identification byte 8 is non-zero, and then `sn_valid` is 1. Otherwise `sn_valid` is 0 and `serial_num` is 0.
- R9: The serial byte received in position k (k=0 first) is placed in `serial_num[8*(7-k)+7 : 8*(7-k)]`, so the last byte received ends up in bits 7:0.
- R10: Once `probe_done` rises, it stays 1, all results are held unchanged and `spi_cs_n` stays high until reset. A rejected device reports `byte_size`=0 and `addr_bytes`=0.
- R11: Status bits 7:1 have no effect on the outcome.
- R12: A reset in the middle of a probe abandons it. The next release of reset runs the whole probe again from the status frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | Data to the device |
| spi_miso | input | 1 | Data from the device |
| probe_done | output | 1 | Probe sequence finished |
| dev_present | output | 1 | Device accepted |
| err_code | output | 2 | 0 none, 1 busy, 2 identity mismatch, 3 bad size |
| byte_size | output | SIZE_W (20) | Device size in bytes |
| addr_bytes | output | 2 | Address bytes for accesses (2 or 3) |
| sn_valid | output | 1 | Serial number read and valid |
| serial_num | output | 64 | Byte-reversed serial number |

## Verification
Every result becomes valid in the cycle where `probe_done` first reads 1. The number of cycles before that depends on `HALF_DIV` and on how many frames the device answer causes: one, two or three frames of 2, 10 or 9 bytes. For that reason the bench does not count a fixed latency. It samples on the falling clock edge, waits for `probe_done` within a bounded window, and compares every result in the first sample where it is high. It then waits a further 60 cycles and samples again, to confirm that nothing moved and no new frame began. A device model in the bench records each frame's opcode and number of clock edges, so the order and length of the SPI transactions are checked at the pins.

// File: rtl/fram_probe_pkg.sv
// Package: shared constants and types for the FRAM probe sequencer.
// Assumes byte-wide SPI transactions and the identification layout the
// block decodes (manufacturer, density and serial flag at fixed positions).
package fram_probe_pkg;

    // Opcodes sent as the first byte of each frame
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_RD_IDENT  = 8'h9F;
    localparam logic [7:0] OP_RD_SERIAL = 8'hC3;

    // Number of bytes received after the opcode in each frame
    localparam int STATUS_LEN = 1;
    localparam int ID_LEN     = 9;
    localparam int SN_LEN     = 8;

    // Positions inside the identification string (0 = first received)
    localparam int MFR_POS    = 6;
    localparam int DENS_POS   = 7;
    localparam int SNFLAG_POS = 8;

    // Accepted identity values
    localparam logic [7:0] MFR_EXPECT = 8'hC2;
    localparam logic [7:0] DENS_LO    = 8'h21;
    localparam logic [7:0] DENS_HI    = 8'h26;

    // log2 of the size in bytes for the lowest density code (16 KiB)
    localparam int DENS_SHIFT_BASE = 14;
    // Largest log2 size still reachable with two address bytes
    localparam int TWO_BYTE_MAX_LOG2 = 16;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_BUSY  = 2'd1,
        ERR_IDENT = 2'd2,
        ERR_SIZE  = 2'd3
    } probe_err_e;

    typedef enum logic [1:0] {
        PH_STATUS,
        PH_IDENT,
        PH_SERIAL
    } probe_phase_e;

    typedef enum logic [2:0] {
        FS_LAUNCH,
        FS_OPCODE,
        FS_OP_WAIT,
        FS_DATA,
        FS_DATA_WAIT,
        FS_DESELECT,
        FS_DECIDE,
        FS_HOLD
    } probe_state_e;

endpackage

// File: rtl/fram_spi_byte.sv
// Module: one-byte SPI mode-0 shifter.
// Shifts tx_byte out MSB first while shifting MISO in. SCLK idles low, MISO
// is sampled on each rising edge and MOSI advances on each falling edge.
// Each SCLK phase lasts HALF_DIV clk cycles. done pulses for one cycle after
// the eighth falling edge, and rx_byte holds its value until the next start.
// Assumes start is raised only while no byte is in flight.
module fram_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic             busy_q;
    logic             sclk_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;

    // Phase timer and shift registers for one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    tx_q   <= tx_byte;
                    cnt_q  <= '0;
                    bit_q  <= '0;
                end
            end else if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[6:0], 1'b0};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;

endmodule

// File: rtl/fram_id_decode.sv
// Module: combinational decoder for the identity bytes.
// Checks the manufacturer byte and the density code range. It turns the
// density code into a power-of-two byte size and picks 2 or 3 address bytes.
// size_bytes is zero when the code is out of range.
// Assumes SIZE_W is wide enough for the largest size (20 bits for 512 KiB).
module fram_id_decode
    import fram_probe_pkg::*;
#(
    parameter int SIZE_W = 20
) (
    input  logic [7:0]        mfr_byte,
    input  logic [7:0]        dens_byte,
    output logic              mfr_ok,
    output logic              size_ok,
    output logic [SIZE_W-1:0] size_bytes,
    output logic [1:0]        addr_bytes
);
    logic [7:0] dens_off;
    logic [7:0] size_log2;

    // Range check, size exponent and address length from the density code
    always_comb begin
        mfr_ok     = (mfr_byte == MFR_EXPECT);
        size_ok    = (dens_byte >= DENS_LO) && (dens_byte <= DENS_HI);
        dens_off   = dens_byte - DENS_LO;
        size_log2  = dens_off + 8'(DENS_SHIFT_BASE);
        size_bytes = size_ok ? (SIZE_W'(1) << size_log2) : '0;
        addr_bytes = (size_log2 > 8'(TWO_BYTE_MAX_LOG2)) ? 2'd3 : 2'd2;
    end

endmodule

// File: rtl/fram_sn_store.sv
// Module: serial-number store with reversed byte placement.
// The byte written with index k goes to slot NB-1-k, so the last byte
// received ends up in bits 7:0. Slots are cleared only by reset.
module fram_sn_store #(
    parameter int NB = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_byte,
    output logic [NB*8-1:0]       sn_out
);
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        logic [7:0] slot_q;

        // Load this slot when its mirrored index arrives
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(NB - 1 - g))) begin
                slot_q <= wr_byte;
            end
        end

        assign sn_out[8*g +: 8] = slot_q;
    end

endmodule

// File: rtl/fram_probe_seq.sv
// Module: FRAM identification probe sequencer (top).
// After reset it runs three SPI frames in turn: status, identification and,
// if the device reports one, the serial number. It then decides presence,
// size and address length, and holds the results with probe_done high until
// the next reset.
// Assumes one device on the bus, and that nothing else drives the bus
// during the probe.
module fram_probe_seq
    import fram_probe_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int SIZE_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              probe_done,
    output logic              dev_present,
    output logic [1:0]        err_code,
    output logic [SIZE_W-1:0] byte_size,
    output logic [1:0]        addr_bytes,
    output logic              sn_valid,
    output logic [63:0]       serial_num
);
    localparam int IDX_W    = $clog2(ID_LEN);
    localparam int SN_IDX_W = $clog2(SN_LEN);
    localparam int GAP_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    probe_state_e      state_q;
    probe_phase_e      phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [GAP_W-1:0]  gap_q;
    logic              cs_n_q;
    logic              busy_bit_q;
    logic [7:0]        mfr_q;
    logic [7:0]        dens_q;
    logic              snflag_q;
    logic              done_q;
    logic              present_q;
    probe_err_e        err_q;
    logic [SIZE_W-1:0] size_q;
    logic [1:0]        addr_q;
    logic              snv_q;

    logic              xfer_start;
    logic [7:0]        xfer_tx;
    logic              xfer_done;
    logic [7:0]        xfer_rx;
    logic [7:0]        opcode;

    logic              dec_mfr_ok;
    logic              dec_size_ok;
    logic [SIZE_W-1:0] dec_size;
    logic [1:0]        dec_addr;
    logic              sn_wr;

    // Opcode and final byte index of the frame for the current phase
    always_comb begin
        unique case (phase_q)
            PH_STATUS: begin
                opcode   = OP_RD_STATUS;
                last_idx = IDX_W'(STATUS_LEN - 1);
            end
            PH_IDENT: begin
                opcode   = OP_RD_IDENT;
                last_idx = IDX_W'(ID_LEN - 1);
            end
            default: begin
                opcode   = OP_RD_SERIAL;
                last_idx = IDX_W'(SN_LEN - 1);
            end
        endcase
    end

    // Start the shifter on the opcode and on each dummy byte
    always_comb begin
        xfer_start = (state_q == FS_OPCODE) || (state_q == FS_DATA);
        xfer_tx    = (state_q == FS_OPCODE) ? opcode : 8'h00;
        sn_wr      = (state_q == FS_DATA_WAIT) && xfer_done && (phase_q == PH_SERIAL);
    end

    fram_spi_byte #(
        .HALF_DIV (HALF_DIV)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .tx_byte (xfer_tx),
        .done    (xfer_done),
        .rx_byte (xfer_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    fram_id_decode #(
        .SIZE_W (SIZE_W)
    ) u_dec (
        .mfr_byte   (mfr_q),
        .dens_byte  (dens_q),
        .mfr_ok     (dec_mfr_ok),
        .size_ok    (dec_size_ok),
        .size_bytes (dec_size),
        .addr_bytes (dec_addr)
    );

    fram_sn_store #(
        .NB (SN_LEN)
    ) u_sn (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sn_wr),
        .wr_idx  (idx_q[SN_IDX_W-1:0]),
        .wr_byte (xfer_rx),
        .sn_out  (serial_num)
    );

    // Probe sequencer: frame framing, byte capture and the final decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FS_LAUNCH;
            phase_q    <= PH_STATUS;
            idx_q      <= '0;
            gap_q      <= '0;
            cs_n_q     <= 1'b1;
            busy_bit_q <= 1'b0;
            mfr_q      <= '0;
            dens_q     <= '0;
            snflag_q   <= 1'b0;
            done_q     <= 1'b0;
            present_q  <= 1'b0;
            err_q      <= ERR_NONE;
            size_q     <= '0;
            addr_q     <= '0;
            snv_q      <= 1'b0;
        end else begin
            unique case (state_q)
                FS_LAUNCH: begin
                    cs_n_q  <= 1'b0;
                    state_q <= FS_OPCODE;
                end
                FS_OPCODE: begin
                    state_q <= FS_OP_WAIT;
                end
                FS_OP_WAIT: begin
                    if (xfer_done) begin
                        idx_q   <= '0;
                        state_q <= FS_DATA;
                    end
                end
                FS_DATA: begin
                    state_q <= FS_DATA_WAIT;
                end
                FS_DATA_WAIT: begin
                    if (xfer_done) begin
                        if (phase_q == PH_STATUS) begin
                            busy_bit_q <= xfer_rx[0];
                        end else if (phase_q == PH_IDENT) begin
                            if (idx_q == IDX_W'(MFR_POS))    mfr_q    <= xfer_rx;
                            if (idx_q == IDX_W'(DENS_POS))   dens_q   <= xfer_rx;
                            if (idx_q == IDX_W'(SNFLAG_POS)) snflag_q <= |xfer_rx;
                        end
                        if (idx_q == last_idx) begin
                            cs_n_q  <= 1'b1;
                            gap_q   <= '0;
                            state_q <= FS_DESELECT;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= FS_DATA;
                        end
                    end
                end
                FS_DESELECT: begin
                    if (gap_q == GAP_W'(HALF_DIV - 1)) begin
                        state_q <= FS_DECIDE;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
                FS_DECIDE: begin
                    unique case (phase_q)
                        PH_STATUS: begin
                            if (busy_bit_q) begin
                                err_q   <= ERR_BUSY;
                                done_q  <= 1'b1;
                                state_q <= FS_HOLD;
                            end else begin
                                phase_q <= PH_IDENT;
                                state_q <= FS_LAUNCH;
                            end
                        end
                        PH_IDENT: begin
                            if (!dec_mfr_ok) begin
                                err_q   <= ERR_IDENT;
                                done_q  <= 1'b1;
                                state_q <= FS_HOLD;
                            end else if (!dec_size_ok) begin
                                err_q   <= ERR_SIZE;
                                done_q  <= 1'b1;
                                state_q <= FS_HOLD;
                            end else begin
                                present_q <= 1'b1;
                                size_q    <= dec_size;
                                addr_q    <= dec_addr;
                                if (snflag_q) begin
                                    phase_q <= PH_SERIAL;
                                    state_q <= FS_LAUNCH;
                                end else begin
                                    done_q  <= 1'b1;
                                    state_q <= FS_HOLD;
                                end
                            end
                        end
                        default: begin
                            snv_q   <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= FS_HOLD;
                        end
                    endcase
                end
                default: begin
                    state_q <= FS_HOLD;
                end
            endcase
        end
    end

    assign spi_cs_n    = cs_n_q;
    assign probe_done  = done_q;
    assign dev_present = present_q;
    assign err_code    = err_q;
    assign byte_size   = size_q;
    assign addr_bytes  = addr_q;
    assign sn_valid    = snv_q;

endmodule

// File: rtl/fram_probe_chk.sv
// Module: assertion checker bound to fram_probe_seq.
// Checks the relations between the probe outputs and the SPI pins over time.
module fram_probe_chk #(
    parameter int SIZE_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              probe_done,
    input logic              dev_present,
    input logic [1:0]        err_code,
    input logic [SIZE_W-1:0] byte_size,
    input logic [1:0]        addr_bytes,
    input logic              sn_valid,
    input logic [63:0]       serial_num
);
    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |=> probe_done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |=> ($stable(dev_present) && $stable(err_code) && $stable(byte_size)
                        && $stable(addr_bytes) && $stable(sn_valid) && $stable(serial_num)));

    // R10
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |-> spi_cs_n);

    // R3
    present_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_present |-> (err_code == 2'd0));

    // R5
    reject_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && !dev_present) |-> (err_code != 2'd0 && byte_size == '0 && addr_bytes == 2'd0));

    // R6
    size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && dev_present) |-> ($countones(byte_size) == 1));

    // R7
    addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && dev_present) |->
            (addr_bytes == ((byte_size > SIZE_W'(65536)) ? 2'd3 : 2'd2)));

    // R8
    sn_needs_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sn_valid |-> dev_present);

    // R8
    sn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && !sn_valid) |-> (serial_num == 64'd0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n && !probe_done && !dev_present && !sn_valid));

endmodule

bind fram_probe_seq fram_probe_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_sclk    (spi_sclk),
    .probe_done  (probe_done),
    .dev_present (dev_present),
    .err_code    (err_code),
    .byte_size   (byte_size),
    .addr_bytes  (addr_bytes),
    .sn_valid    (sn_valid),
    .serial_num  (serial_num)
);

// File: tb/fram_probe_seq_tb.sv
// Testbench: a device model answers the status, identification and serial
// opcodes. A vector table covers the device answers, then directed tests
// cover reset and an aborted probe.
module fram_probe_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SIZE_W     = 20;
    localparam int WAIT_MAX   = 4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_cs_n, spi_sclk, spi_mosi;
    logic              spi_miso = 1'b0;
    logic              probe_done, dev_present, sn_valid;
    logic [1:0]        err_code, addr_bytes;
    logic [SIZE_W-1:0] byte_size;
    logic [63:0]       serial_num;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fram_probe_seq #(.HALF_DIV(2), .SIZE_W(SIZE_W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .spi_cs_n (spi_cs_n), .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi), .spi_miso (spi_miso),
        .probe_done (probe_done), .dev_present (dev_present),
        .err_code (err_code), .byte_size (byte_size),
        .addr_bytes (addr_bytes), .sn_valid (sn_valid),
        .serial_num (serial_num)
    );

    // ---------------- device model ----------------
    logic [7:0]  m_status = 8'h00, m_mfr = 8'h00, m_dens = 8'h00, m_snf = 8'h00;
    logic [63:0] m_sn = 64'd0;
    int          rises = 0;
    logic [7:0]  op_cap = 8'h00;
    int          nframes = 0;
    logic [7:0]  fr_op [4];
    int          fr_rises [4];

    function automatic logic [7:0] resp_byte(input logic [7:0] op, input int idx);
        logic [7:0] r;
        r = 8'h00;
        if (op == 8'h05 && idx == 0) r = m_status;
        else if (op == 8'h9F) begin
            if (idx == 6)      r = m_mfr;
            else if (idx == 7) r = m_dens;
            else if (idx == 8) r = m_snf;
            else if (idx < 6)  r = 8'h7F;
        end else if (op == 8'hC3 && idx < 8) r = m_sn[8*idx +: 8];
        return r;
    endfunction

    always @(negedge spi_cs_n) begin
        rises  = 0;
        op_cap = 8'h00;
    end

    always @(posedge spi_cs_n) begin
        if (rst_n === 1'b1 && nframes < 4) begin
            fr_op[nframes]    = op_cap;
            fr_rises[nframes] = rises;
            nframes++;
        end
    end

    always @(posedge spi_sclk) begin
        if (rises < 8) op_cap = {op_cap[6:0], spi_mosi};
        rises++;
    end

    always @(negedge spi_sclk) begin
        if (rises >= 8) begin
            int b;
            logic [7:0] rb;
            b  = rises - 8;
            rb = resp_byte(op_cap, b / 8);
            spi_miso = rb[7 - (b % 8)];
        end
    end

    // ---------------- vectors ----------------
    typedef struct packed {
        logic [7:0]        st;
        logic [7:0]        mfr;
        logic [7:0]        dens;
        logic [7:0]        snf;
        logic [63:0]       sn;
        logic              e_pres;
        logic [1:0]        e_err;
        logic [SIZE_W-1:0] e_size;
        logic [1:0]        e_addr;
        logic              e_snv;
        logic [1:0]        e_frames;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'hC2, 8'h21, 8'h00, 64'h0,                  1'b1, 2'd0, 20'd16384,  2'd2, 1'b0, 2'd2},
        '{8'h00, 8'hC2, 8'h22, 8'h00, 64'h0,                  1'b1, 2'd0, 20'd32768,  2'd2, 1'b0, 2'd2},
        '{8'h00, 8'hC2, 8'h23, 8'h00, 64'h0,                  1'b1, 2'd0, 20'd65536,  2'd2, 1'b0, 2'd2},
        '{8'h00, 8'hC2, 8'h24, 8'h01, 64'h8877665544332211,   1'b1, 2'd0, 20'd131072, 2'd3, 1'b1, 2'd3},
        '{8'h00, 8'hC2, 8'h25, 8'h00, 64'h0,                  1'b1, 2'd0, 20'd262144, 2'd3, 1'b0, 2'd2},
        '{8'h02, 8'hC2, 8'h26, 8'hA5, 64'h0F1E2D3C4B5A6978,   1'b1, 2'd0, 20'd524288, 2'd3, 1'b1, 2'd3},
        '{8'h01, 8'hC2, 8'h21, 8'h00, 64'h0,                  1'b0, 2'd1, 20'd0,      2'd0, 1'b0, 2'd1},
        '{8'h00, 8'hC1, 8'h21, 8'h01, 64'h1111111111111111,   1'b0, 2'd2, 20'd0,      2'd0, 1'b0, 2'd2},
        '{8'h00, 8'hC2, 8'h20, 8'h01, 64'h2222222222222222,   1'b0, 2'd3, 20'd0,      2'd0, 1'b0, 2'd2},
        '{8'h00, 8'hC2, 8'h27, 8'h00, 64'h0,                  1'b0, 2'd3, 20'd0,      2'd0, 1'b0, 2'd2},
        '{8'h00, 8'h3C, 8'h30, 8'hFF, 64'h3333333333333333,   1'b0, 2'd2, 20'd0,      2'd0, 1'b0, 2'd2},
        '{8'hFE, 8'hC2, 8'h23, 8'h01, 64'hDEADBEEF01020304,   1'b1, 2'd0, 20'd65536,  2'd2, 1'b1, 2'd3},
        '{8'hFF, 8'hC2, 8'h24, 8'h00, 64'h0,                  1'b0, 2'd1, 20'd0,      2'd0, 1'b0, 2'd1}
    };

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rev_sn(input logic [63:0] s);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*(7-k) +: 8] = s[8*k +: 8];
        return r;
    endfunction

    task automatic load_model(input vec_t v);
        m_status = v.st;
        m_mfr    = v.mfr;
        m_dens   = v.dens;
        m_snf    = v.snf;
        m_sn     = v.sn;
    endtask

    task automatic check_reset_state(input string req);
        chk(req, "reset outputs",
            {39'd0, spi_cs_n, spi_sclk, probe_done, dev_present, err_code,
             byte_size},
            {39'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 20'd0});
        chk(req, "reset addr/sn", {61'd0, addr_bytes, sn_valid}, 64'd0);
        chk(req, "reset serial", serial_num, 64'd0);
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (probe_done !== 1'b1 && n < WAIT_MAX) begin
            @(negedge clk);
            n++;
        end
        chk(req, "probe_done reached", {63'd0, probe_done}, 64'd1);
    endtask

    task automatic check_results(input vec_t v);
        logic [63:0] exp_sn;
        exp_sn = v.e_snv ? rev_sn(v.sn) : 64'd0;
        chk("R3/R4/R5", "dev_present", {63'd0, dev_present}, {63'd0, v.e_pres});
        chk("R3/R4/R5", "err_code", {62'd0, err_code}, {62'd0, v.e_err});
        chk("R6", "byte_size", {44'd0, byte_size}, {44'd0, v.e_size});
        chk("R7", "addr_bytes", {62'd0, addr_bytes}, {62'd0, v.e_addr});
        chk("R8", "sn_valid", {63'd0, sn_valid}, {63'd0, v.e_snv});
        chk("R9", "serial_num", serial_num, exp_sn);
        chk("R2", "frame count", 64'(nframes), {62'd0, v.e_frames});
        if (nframes >= 1) begin
            chk("R2", "frame0 opcode", {56'd0, fr_op[0]}, 64'h05);
            chk("R2", "frame0 edges", 64'(fr_rises[0]), 64'd16);
        end
        if (nframes >= 2) begin
            chk("R2", "frame1 opcode", {56'd0, fr_op[1]}, 64'h9F);
            chk("R2", "frame1 edges", 64'(fr_rises[1]), 64'd80);
        end
        if (nframes >= 3) begin
            chk("R8", "frame2 opcode", {56'd0, fr_op[2]}, 64'hC3);
            chk("R2", "frame2 edges", 64'(fr_rises[2]), 64'd72);
        end
    endtask

    task automatic check_hold();
        logic [63:0] snap_a, snap_b;
        int          fr0;
        snap_a = {36'd0, dev_present, err_code, byte_size, addr_bytes, sn_valid};
        snap_b = serial_num;
        fr0    = nframes;
        repeat (60) @(negedge clk);
        chk("R10", "done held", {62'd0, probe_done, spi_cs_n}, 64'd3);
        chk("R10", "results held",
            {36'd0, dev_present, err_code, byte_size, addr_bytes, sn_valid}, snap_a);
        chk("R10", "serial held", serial_num, snap_b);
        chk("R10", "no new frame", 64'(nframes), 64'(fr0));
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        rst_n = 1'b0;
        load_model(v);
        repeat (3) @(negedge clk);
        nframes = 0;
        check_reset_state("R1");
        rst_n = 1'b1;
        wait_done("R10");
        check_results(v);
        check_hold();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        // R1: outputs during reset before any probe
        repeat (3) @(negedge clk);
        check_reset_state("R1");

        // Table walk: R2..R11 across device answers
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R12: abort a probe mid-identification, then rerun with another device
        @(negedge clk);
        rst_n = 1'b0;
        load_model(VECS[3]);
        repeat (3) @(negedge clk);
        nframes = 0;
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk("R12", "probe still running", {63'd0, probe_done}, 64'd0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state("R12");
        load_model(VECS[5]);
        nframes = 0;
        rst_n = 1'b1;
        wait_done("R12");
        check_results(VECS[5]);

        // R11: status with every bit except bit 0 set still accepted
        run_vec(VECS[11]);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule